// File: doc/BRIEF.md
# ALU Status Flags and Branch Condition Unit

This block sits next to a small adder and logic unit inside a processor datapath. It performs add, subtract, bitwise AND, OR, XOR and a plain pass of operand A. From each operation it works out four status bits: carry, sign, zero and overflow. These bits go into a status register that loads only on clocks where the update enable is high. Subtraction is done by adding the inverted second operand with a carry-in of one. Overflow comes from the two carries at the top bit position, which are the carry into the most significant bit and the carry out of it.

Two of the operation codes set the status bits without producing a new value. Compare takes its flags from A minus B, and test takes its flags from A AND B. For both, the result port shows operand A unchanged, so a write-back path that uses the result stores nothing new. A 3-bit condition select picks one of eight branch tests. Each test looks at one registered status bit in its true or inverted sense, and the chosen test drives a single branch-taken output.

The data width is a parameter with a default of 8 bits. The reset input is asynchronous and active low. Its assertion clears the status register at once, and its release is synchronized to the clock inside the block.

Top module: `flag_branch_unit`

## Requirements
- R1: Operation code 001 (add) drives the result port with (A + B) mod 2^W, and the carry flag is set to the carry out of the top bit.
- R2: Operation code 010 (subtract) drives the result port with A + ~B + 1 mod 2^W. The carry flag is 1 when no borrow occurs, so F0 minus 14 gives DC with carry 1, sign 1, overflow 0 and zero 0.
- R3: For add, subtract and compare, the overflow flag is the carry into bit W-1 XOR the carry out of bit W-1. Adding two operands whose top bits differ never sets it.
- R4: The sign flag equals the top bit of the value the flags are taken from. The zero flag is 1 exactly when every bit of that value is 0.
- R5: Operation codes 000 (pass A), 100 (AND), 101 (OR) and 110 (XOR) drive the result port with the named function and clear both carry and overflow.
- R6: Operation code 011 (compare) takes all four flags from A - B, and the result port shows A.
- R7: Operation code 111 (test) takes the flags from A AND B, with carry and overflow cleared, and the result port shows A.
- R8: The status flags change only on a rising clock edge where the update enable is high. On all other edges they keep their value, while the result port still follows the operands.
- R9: The branch-taken output is computed from the registered flags. The condition select values map as follows: 000 zero=1, 001 zero=0, 010 carry=1, 011 carry=0, 100 sign=0, 101 sign=1, 110 overflow=1, 111 overflow=0.
- R10: While reset is low, all four flags are 0 with no clock edge needed. Branch-taken is therefore 1 only for condition selects 001, 011, 100 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opd_a | input | W | First operand |
| opd_b | input | W | Second operand |
| op_sel | input | 3 | Operation code |
| upd_en | input | 1 | Load the status register on this clock |
| cond_sel | input | 3 | Branch condition select |
| result | output | W | Operation result, or A for compare and test |
| flag_c | output | 1 | Registered carry |
| flag_s | output | 1 | Registered sign |
| flag_z | output | 1 | Registered zero |
| flag_v | output | 1 | Registered overflow |
| br_taken | output | 1 | Selected condition is true |

## Verification
The hardest cases to reach from the ports are the ones where the carry into the top bit and the carry out of it disagree. Those are the only cases that set overflow. They also include the case where the carry out is set while the sum is zero. The stimulus reaches them with chosen operand pairs: 7F+01, 80+80, 80+FF and 80-01. Each of these vectors is followed by a logic operation, which shows that carry and overflow are cleared again. A further directed step loads flags and then changes the operands with the update enable low. This shows that the result moves while the flags and the branch decision stay where they were.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_ADD  = 3'b001,
    OP_SUB  = 3'b010,
    OP_CMP  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_TST  = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_ZERO   = 3'b000,
    CC_NZERO  = 3'b001,
    CC_CARRY  = 3'b010,
    CC_NCARRY = 3'b011,
    CC_PLUS   = 3'b100,
    CC_MINUS  = 3'b101,
    CC_OVF    = 3'b110,
    CC_NOVF   = 3'b111
  } cond_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_unit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  alu_op_e      op,
  output logic [W-1:0] result,
  output flags_t       nxt_flags
);
  localparam int MSB = W - 1;

  logic         is_arith;
  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] low_sum;
  logic         c_into_msb;
  logic [1:0]   msb_sum;
  logic [W-1:0] arith_val;
  logic [W-1:0] src_val;

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    is_sub   = (op == OP_SUB) || (op == OP_CMP);
    b_eff    = is_sub ? ~opd_b : opd_b;
    // lower W-1 bits, bit MSB of low_sum is the carry into the top bit
    low_sum    = {1'b0, opd_a[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]}
               + {{(W-1){1'b0}}, is_sub};
    c_into_msb = low_sum[MSB];
    msb_sum    = {1'b0, opd_a[MSB]} + {1'b0, b_eff[MSB]} + {1'b0, c_into_msb};
    arith_val  = {msb_sum[0], low_sum[MSB-1:0]};

    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: src_val = arith_val;
      OP_AND, OP_TST:         src_val = opd_a & opd_b;
      OP_OR:                  src_val = opd_a | opd_b;
      OP_XOR:                 src_val = opd_a ^ opd_b;
      default:                src_val = opd_a;
    endcase

    result = ((op == OP_CMP) || (op == OP_TST)) ? opd_a : src_val;

    nxt_flags.c = is_arith & msb_sum[1];
    nxt_flags.v = is_arith & (c_into_msb ^ msb_sum[1]);
    nxt_flags.s = src_val[MSB];
    nxt_flags.z = ~|src_val;
  end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
  import flag_unit_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en,
  input  flags_t d,
  output flags_t q
);
  flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (upd_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R8: flags move only when the enable was high
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(q));
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (q == $past(d)));
endmodule

// File: rtl/flag_branch_eval.sv
module flag_branch_eval
  import flag_unit_pkg::*;
(
  input  flags_t     flags,
  input  logic [2:0] cond_sel,
  output logic       taken
);
  cond_e cond;

  always_comb begin
    cond = cond_e'(cond_sel);
    unique case (cond)
      CC_ZERO:   taken =  flags.z;
      CC_NZERO:  taken = ~flags.z;
      CC_CARRY:  taken =  flags.c;
      CC_NCARRY: taken = ~flags.c;
      CC_PLUS:   taken = ~flags.s;
      CC_MINUS:  taken =  flags.s;
      CC_OVF:    taken =  flags.v;
      default:   taken = ~flags.v;
    endcase
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import flag_unit_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic [2:0]   op_sel,
  input  logic         upd_en,
  input  logic [2:0]   cond_sel,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_v,
  output logic         br_taken
);
  logic    rst_sync_n;
  logic    arst_n;
  alu_op_e op;
  flags_t  nxt_flags;
  flags_t  cur_flags;

  assign op = alu_op_e'(op_sel);
  // assertion is immediate, release follows the synchronizer
  assign arst_n = rst_n & rst_sync_n;

  flag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flag_alu_core #(.W(W)) u_core (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .op        (op),
    .result    (result),
    .nxt_flags (nxt_flags)
  );

  flag_status_reg u_status (
    .clk    (clk),
    .rst_n  (arst_n),
    .upd_en (upd_en),
    .d      (nxt_flags),
    .q      (cur_flags)
  );

  flag_branch_eval u_branch (
    .flags    (cur_flags),
    .cond_sel (cond_sel),
    .taken    (br_taken)
  );

  assign flag_c = cur_flags.c;
  assign flag_s = cur_flags.s;
  assign flag_z = cur_flags.z;
  assign flag_v = cur_flags.v;

  // R3: adding operands of opposite sign never overflows
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!arst_n)
    (upd_en && op == OP_ADD && (opd_a[W-1] != opd_b[W-1])) |=> !flag_v);
  // R5: logic operations leave carry and overflow clear
  a_r5_logic_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (upd_en && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_PASS))
      |=> (!flag_c && !flag_v));
  // R4: a zero result written back sets the zero flag
  a_r4_zero_result: assert property (@(posedge clk) disable iff (!arst_n)
    (upd_en && op != OP_CMP && op != OP_TST && result == '0) |=> flag_z);
  // R6 / R7: compare and test show operand A on the result port
  a_r6_r7_no_writeback: assert property (@(posedge clk) disable iff (!arst_n)
    (op == OP_CMP || op == OP_TST) |-> (result == opd_a));
endmodule

// File: tb/flag_branch_unit_bench.sv
module flag_branch_unit_bench;
  localparam int W  = 8;
  localparam int NV = 17;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opd_a, opd_b;
  logic [2:0]   op_sel, cond_sel;
  logic         upd_en;
  logic [W-1:0] result;
  logic         flag_c, flag_s, flag_z, flag_v, br_taken;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  // {op, a, b, expected result, expected {C,S,Z,V}}, requirement tag in comment
  localparam logic [30:0] VEC [NV] = '{
    {3'b001, 8'h01, 8'h02, 8'h03, 4'b0000},  // R1
    {3'b001, 8'hFF, 8'h01, 8'h00, 4'b1010},  // R1 R4
    {3'b001, 8'h7F, 8'h01, 8'h80, 4'b0101},  // R3
    {3'b100, 8'hF0, 8'h3C, 8'h30, 4'b0000},  // R5 clears V
    {3'b001, 8'h80, 8'h80, 8'h00, 4'b1011},  // R3
    {3'b101, 8'h80, 8'h01, 8'h81, 4'b0100},  // R5 clears C
    {3'b010, 8'hF0, 8'h14, 8'hDC, 4'b1100},  // R2
    {3'b010, 8'h05, 8'h05, 8'h00, 4'b1010},  // R2 R4
    {3'b010, 8'h03, 8'h05, 8'hFE, 4'b0100},  // R2 borrow
    {3'b010, 8'h80, 8'h01, 8'h7F, 4'b1001},  // R3
    {3'b110, 8'hAA, 8'hAA, 8'h00, 4'b0010},  // R5
    {3'b001, 8'h80, 8'hFF, 8'h7F, 4'b1001},  // R3
    {3'b000, 8'h00, 8'hFF, 8'h00, 4'b0010},  // R5 pass
    {3'b011, 8'h10, 8'h20, 8'h10, 4'b0100},  // R6
    {3'b011, 8'h7F, 8'h7F, 8'h7F, 4'b1010},  // R6
    {3'b111, 8'h0F, 8'hF0, 8'h0F, 4'b0010},  // R7
    {3'b111, 8'h81, 8'h80, 8'h81, 4'b0100}   // R7
  };

  flag_branch_unit #(.W(W)) u_flag_branch_unit (
    .clk(clk), .rst_n(rst_n), .opd_a(opd_a), .opd_b(opd_b),
    .op_sel(op_sel), .upd_en(upd_en), .cond_sel(cond_sel),
    .result(result), .flag_c(flag_c), .flag_s(flag_s),
    .flag_z(flag_z), .flag_v(flag_v), .br_taken(br_taken)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic exp_taken(input logic [3:0] f, input logic [2:0] cs);
    logic c, s, z, v;
    {c, s, z, v} = f;
    case (cs)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return c;
      3'd3: return !c;
      3'd4: return !s;
      3'd5: return s;
      3'd6: return v;
      default: return !v;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_branches(input string req, input logic [3:0] f);
    for (int k = 0; k < 8; k++) begin
      cond_sel = 3'(k);
      #1;
      check(req, {31'd0, br_taken}, {31'd0, exp_taken(f, 3'(k))});
    end
  endtask

  initial begin
    rst_n = 1'b0; opd_a = '0; opd_b = '0; op_sel = '0; upd_en = 1'b0; cond_sel = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 flags", {28'd0, flag_c, flag_s, flag_z, flag_v}, 32'h0);
    check_branches("R10 branch", 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] ef;
      ef = VEC[i][3:0];
      op_sel = VEC[i][30:28]; opd_a = VEC[i][27:20]; opd_b = VEC[i][19:12];
      upd_en = 1'b1;
      #1;
      check($sformatf("R1/R2/R5/R6/R7 result vec %0d", i), {24'd0, result}, {24'd0, VEC[i][11:4]});
      @(negedge clk);
      upd_en = 1'b0;
      check($sformatf("R2/R3/R4 flags vec %0d", i),
            {28'd0, flag_c, flag_s, flag_z, flag_v}, {28'd0, ef});
      check_branches($sformatf("R9 vec %0d", i), ef);
    end

    // R8: load, then change operands with enable low
    @(negedge clk);
    op_sel = 3'b001; opd_a = 8'hFF; opd_b = 8'h01; upd_en = 1'b1;
    @(negedge clk);
    opd_a = 8'h01; opd_b = 8'h01; upd_en = 1'b0;
    #1;
    check("R8 result follows", {24'd0, result}, 32'h02);
    repeat (2) @(negedge clk);
    check("R8 flags held", {28'd0, flag_c, flag_s, flag_z, flag_v}, 32'hA);
    check_branches("R8 R9 held", 4'b1010);

    // R10: reset clears flags without a clock edge
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 async clear", {28'd0, flag_c, flag_s, flag_z, flag_v}, 32'h0);
    check_branches("R10 branch after clear", 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule